// File: doc/BRIEF.md
# 24-Bit Fixed-Point DSP Instruction Executor

This block fetches 24-bit program words from an internal program memory and executes a small subset of a fixed-point DSP instruction set. The subset covers six kinds of word. Immediate loads write a data register, an index register or the loop counter. A compute word either adds into the accumulator result register or forms a signed product into the multiplier result register. A short conditional jump carries a 13-bit target. A long jump or call carries a 16-bit target, split across the word. Both jump forms can be made delayed, so that the two words after the branch still execute.

A program is written through the load port while reset is held low. Once reset is released, the sequencer executes one word per clock, starting from address 0x0000. It stops at a halt word, and the register file and flags are then read back through a selector port. A call pushes its return address onto a small PC stack. This design has no return instruction, so the stack top and depth are visible only through the read-back port.

Top module: `dsp24_core`

## Requirements
- R1: After reset the program counter is 0x0000, the block is not halted, and every register, the zero flag and the stack depth are zero. The first clock edge after release executes the word at address 0. Read-back selector codes are 0 AX0, 1 AX1, 2 MX0, 3 AY0, 4 MY0, 5 AR, 6 MR[15:0], 7 MR[31:16], 8 I0, 9 I1, 10 I4, 11 loop counter, 12 stack top and 13 stack depth; all other codes read zero.
- R2: A word with bits 23-20 = 0100 loads the immediate in bits 19-4 into the data register named by bits 3-0. The codes are 0 AX0, 1 AX1, 2 MX0, 4 AY0, 6 MY0 and 10 AR. Any other code changes no register.
- R3: Bits 23-20 = 0101 load bits 19-4 into the first register group, with code 0 for I0, 1 for I1 and 14 for the loop counter. Bits 23-20 = 0011 load the second group, with code 0 for I4.
- R4: A compute word (bits 23-21 = 001, bits 20-19 = 00) with function bits 17-13 = 10011 writes X+Y, taken modulo 2^16, to AR. Each add that executes sets the zero flag exactly when the sum is zero. For the add, X in bits 10-8 is 0 AX0, 1 AX1 or 2 AR, and Y in bits 12-11 is 0 AY0. Other operand codes read zero.
- R5: Function bits 17-13 = 00100 write the 32-bit signed product X*Y to MR and leave the zero flag unchanged. For the multiply, X code 0 is MX0 and code 2 is AR, and Y code 0 is MY0.
- R6: The condition in bits 3-0 of a compute word or short jump is evaluated as follows: 1111 is always true, 0000 is true when the zero flag is set, 0001 is true when it is clear, and every other code is false. A word whose condition is false has no effect.
- R7: A short jump has bits 23-20 = 0001, bit 19 = 1 and bit 18 = 0, with its target in bits 16-4. When taken without delay, the next word executed is the one at the target. When not taken, execution falls through to the next address.
- R8: The delay bit is bit 17 for a short jump and bit 3 for a long jump. When it is set, the two words after the branch execute, one per cycle, before the target. When it is clear, those two words are skipped.
- R9: A long jump (bits 23-18 = 000111) is unconditional. Its 16-bit target is bits 1-0 as the top two bits followed by bits 17-4, and the whole 16-bit value appears on the PC output.
- R10: A long jump with bit 2 set is a call. It pushes the return address onto the stack: the branch address + 1 without delay, or + 3 with delay.
- R11: A branch word that sits in one of the two delay slots behaves as a no-op.
- R12: The stack holds 4 entries. A push when the stack is full keeps the depth at 4 and still places the new return address on top.
- R13: The word 0x000000, any word outside the decoded formats, and any compute word with a different function code all behave as no-ops.
- R14: The word 0xFFFFFF halts the block. The halt flag rises at the edge that executes it, and from then on the PC and all registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pm_we_i | input | 1 | Program memory write enable |
| pm_addr_i | input | PM_AW | Program memory write address |
| pm_wdata_i | input | 24 | Program word to write |
| rd_sel_i | input | 4 | Read-back register selector |
| rd_data_o | output | 16 | Selected register value |
| az_o | output | 1 | Zero flag |
| halted_o | output | 1 | Halt reached |
| pc_o | output | 16 | Program counter |

## Verification
Each word takes exactly one clock. Its register or flag result is visible after the edge that executes it, and halt_o rises after the edge that executes the halt word. The bench releases reset on a falling edge and counts falling edges until halt_o is high. That count equals the number of words actually executed, so every taken, skipped or delayed branch is checked as an exact cycle total. The registers are read once the block has halted, through a combinational selector, at a quiet point between edges.

// File: rtl/dsp24_pkg.sv
package dsp24_pkg;
  localparam int unsigned WORD_W = 24;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned PROD_W = 2 * DATA_W;

  localparam logic [WORD_W-1:0] HALT_WORD = 24'hFFFFFF;
  localparam logic [4:0] FN_ADD = 5'b10011;
  localparam logic [4:0] FN_MUL = 5'b00100;
  localparam logic [3:0] CC_EQ  = 4'b0000;
  localparam logic [3:0] CC_NE  = 4'b0001;
  localparam logic [3:0] CC_ALW = 4'b1111;

  typedef enum logic [2:0] {
    OP_NOP, OP_LD_DREG, OP_LD_GRP1, OP_LD_GRP2,
    OP_COMPUTE, OP_JMP_SHORT, OP_JMP_LONG, OP_HALT
  } op_e;

  typedef struct packed {
    op_e               op;
    logic [DATA_W-1:0] imm;
    logic [3:0]        rsel;
    logic [4:0]        fn;
    logic [2:0]        xsel;
    logic [1:0]        ysel;
    logic [3:0]        cond;
    logic              delay;
    logic              call;
    logic [DATA_W-1:0] target;
  } dec_t;
endpackage

// File: rtl/dsp24_pmem.sv
module dsp24_pmem
  import dsp24_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned AW    = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dsp24_decode.sv
module dsp24_decode
  import dsp24_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output dec_t              dec_o
);
  always_comb begin
    dec_o        = '0;
    dec_o.op     = OP_NOP;
    dec_o.imm    = word_i[19:4];
    dec_o.rsel   = word_i[3:0];
    dec_o.fn     = word_i[17:13];
    dec_o.ysel   = word_i[12:11];
    dec_o.xsel   = word_i[10:8];
    dec_o.cond   = word_i[3:0];
    dec_o.call   = word_i[2];
    if (word_i == HALT_WORD) begin
      dec_o.op = OP_HALT;
    end else if (word_i[23:18] == 6'b000111) begin
      dec_o.op     = OP_JMP_LONG;
      dec_o.delay  = word_i[3];
      dec_o.target = {word_i[1:0], word_i[17:4]};  // split address: MSBs at bottom
    end else if (word_i[23:18] == 6'b000110) begin
      dec_o.op     = OP_JMP_SHORT;
      dec_o.delay  = word_i[17];
      dec_o.target = {3'b000, word_i[16:4]};
    end else if (word_i[23:20] == 4'b0100) begin
      dec_o.op = OP_LD_DREG;
    end else if (word_i[23:20] == 4'b0101) begin
      dec_o.op = OP_LD_GRP1;
    end else if (word_i[23:20] == 4'b0011) begin
      dec_o.op = OP_LD_GRP2;
    end else if (word_i[23:19] == 5'b00100) begin
      dec_o.op = OP_COMPUTE;
    end
  end
endmodule

// File: rtl/dsp24_alu.sv
module dsp24_alu
  import dsp24_pkg::*;
(
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  input  logic [3:0]        cond_i,
  input  logic              az_i,
  output logic [DATA_W-1:0] sum_o,
  output logic [PROD_W-1:0] prod_o,
  output logic              cond_ok_o
);
  assign sum_o  = x_i + y_i;
  assign prod_o = PROD_W'($signed(x_i)) * PROD_W'($signed(y_i));

  always_comb begin
    case (cond_i)
      CC_EQ:   cond_ok_o = az_i;
      CC_NE:   cond_ok_o = !az_i;
      CC_ALW:  cond_ok_o = 1'b1;
      default: cond_ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/dsp24_core.sv
module dsp24_core
  import dsp24_pkg::*;
#(
  parameter int unsigned  PM_DEPTH    = 256,
  parameter int unsigned  STACK_DEPTH = 4,
  localparam int unsigned PM_AW       = $clog2(PM_DEPTH),
  localparam int unsigned SCW         = $clog2(STACK_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pm_we_i,
  input  logic [PM_AW-1:0]  pm_addr_i,
  input  logic [WORD_W-1:0] pm_wdata_i,
  input  logic [3:0]        rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              az_o,
  output logic              halted_o,
  output logic [DATA_W-1:0] pc_o
);
  localparam logic [SCW-1:0] STK_FULL = SCW'(STACK_DEPTH);

  logic [DATA_W-1:0] pc_q, pc_d, tgt_q, ret_addr;
  logic              halted_q, az_q;
  logic [1:0]        slot_q;
  logic [DATA_W-1:0] ax0_q, ax1_q, mx0_q, ay0_q, my0_q, ar_q;
  logic [DATA_W-1:0] i0_q, i1_q, i4_q, cntr_q;
  logic [PROD_W-1:0] mr_q;
  logic [DATA_W-1:0] stk_q [STACK_DEPTH];
  logic [SCW-1:0]    stk_cnt_q;

  logic [WORD_W-1:0] word;
  dec_t              dec;
  logic [DATA_W-1:0] x_op, y_op, sum;
  logic [PROD_W-1:0] prod;
  logic              cond_ok, is_mul, run, in_slot, is_halt, take, push, do_add, do_mul;

  dsp24_pmem #(.DEPTH(PM_DEPTH), .AW(PM_AW)) u_pmem (
    .clk_i   (clk_i),
    .we_i    (pm_we_i),
    .waddr_i (pm_addr_i),
    .wdata_i (pm_wdata_i),
    .raddr_i (pc_q[PM_AW-1:0]),
    .rdata_o (word)
  );

  dsp24_decode u_dec (.word_i(word), .dec_o(dec));

  assign is_mul = (dec.fn == FN_MUL);

  always_comb begin
    case (dec.xsel)
      3'd0:    x_op = is_mul ? mx0_q : ax0_q;
      3'd1:    x_op = is_mul ? '0 : ax1_q;
      3'd2:    x_op = ar_q;
      default: x_op = '0;
    endcase
    y_op = (dec.ysel == 2'd0) ? (is_mul ? my0_q : ay0_q) : '0;
  end

  dsp24_alu u_alu (
    .x_i       (x_op),
    .y_i       (y_op),
    .cond_i    (dec.cond),
    .az_i      (az_q),
    .sum_o     (sum),
    .prod_o    (prod),
    .cond_ok_o (cond_ok)
  );

  // control
  assign run      = !halted_q;
  assign in_slot  = (slot_q != 2'd0);
  assign is_halt  = run && (dec.op == OP_HALT);
  // branches inside delay slots are ignored
  assign take     = run && !in_slot &&
                    ((dec.op == OP_JMP_SHORT && cond_ok) || dec.op == OP_JMP_LONG);
  assign push     = take && (dec.op == OP_JMP_LONG) && dec.call;
  assign do_add   = run && (dec.op == OP_COMPUTE) && cond_ok && (dec.fn == FN_ADD);
  assign do_mul   = run && (dec.op == OP_COMPUTE) && cond_ok && is_mul;
  assign ret_addr = pc_q + (dec.delay ? DATA_W'(3) : DATA_W'(1));

  always_comb begin
    if (!run || is_halt)          pc_d = pc_q;
    else if (take && !dec.delay)  pc_d = dec.target;
    else if (slot_q == 2'd1)      pc_d = tgt_q;
    else                          pc_d = pc_q + DATA_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q     <= '0;
      halted_q <= 1'b0;
      slot_q   <= 2'd0;
      tgt_q    <= '0;
    end else begin
      pc_q <= pc_d;
      if (is_halt) halted_q <= 1'b1;
      if (run) begin
        if (take && dec.delay) begin
          slot_q <= 2'd2;
          tgt_q  <= dec.target;
        end else if (in_slot) begin
          slot_q <= slot_q - 2'd1;
        end
      end
    end
  end

  // register file
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {ax0_q, ax1_q, mx0_q, ay0_q, my0_q, ar_q} <= '0;
      {i0_q, i1_q, i4_q, cntr_q}                <= '0;
      mr_q <= '0;
      az_q <= 1'b0;
    end else if (run) begin
      if (dec.op == OP_LD_DREG) begin
        case (dec.rsel)
          4'd0:    ax0_q <= dec.imm;
          4'd1:    ax1_q <= dec.imm;
          4'd2:    mx0_q <= dec.imm;
          4'd4:    ay0_q <= dec.imm;
          4'd6:    my0_q <= dec.imm;
          4'd10:   ar_q  <= dec.imm;
          default: ;
        endcase
      end
      if (dec.op == OP_LD_GRP1) begin
        case (dec.rsel)
          4'd0:    i0_q   <= dec.imm;
          4'd1:    i1_q   <= dec.imm;
          4'd14:   cntr_q <= dec.imm;
          default: ;
        endcase
      end
      if (dec.op == OP_LD_GRP2 && dec.rsel == 4'd0) i4_q <= dec.imm;
      if (do_add) begin
        ar_q <= sum;
        az_q <= (sum == '0);
      end
      if (do_mul) mr_q <= prod;
    end
  end

  // PC stack: shift on push, oldest entry drops out when full
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STACK_DEPTH; k++) stk_q[k] <= '0;
      stk_cnt_q <= '0;
    end else if (push) begin
      for (int k = STACK_DEPTH - 1; k > 0; k--) stk_q[k] <= stk_q[k-1];
      stk_q[0] <= ret_addr;
      if (stk_cnt_q != STK_FULL) stk_cnt_q <= stk_cnt_q + SCW'(1);
    end
  end

  always_comb begin
    case (rd_sel_i)
      4'd0:    rd_data_o = ax0_q;
      4'd1:    rd_data_o = ax1_q;
      4'd2:    rd_data_o = mx0_q;
      4'd3:    rd_data_o = ay0_q;
      4'd4:    rd_data_o = my0_q;
      4'd5:    rd_data_o = ar_q;
      4'd6:    rd_data_o = mr_q[DATA_W-1:0];
      4'd7:    rd_data_o = mr_q[PROD_W-1:DATA_W];
      4'd8:    rd_data_o = i0_q;
      4'd9:    rd_data_o = i1_q;
      4'd10:   rd_data_o = i4_q;
      4'd11:   rd_data_o = cntr_q;
      4'd12:   rd_data_o = stk_q[0];
      4'd13:   rd_data_o = DATA_W'(stk_cnt_q);
      default: rd_data_o = '0;
    endcase
  end

  assign az_o     = az_q;
  assign halted_o = halted_q;
  assign pc_o     = pc_q;

  // R14
  halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_q |=> (halted_q && $stable(pc_q)));

  // R7
  jmp_now_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !dec.delay) |=> (pc_q == $past(dec.target)));

  // R8
  delay_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && dec.delay) |=> (pc_q == $past(pc_q) + DATA_W'(1)));

  // R4
  az_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_add |=> (az_q == (ar_q == '0)));

  // R10
  push_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push && stk_cnt_q != STK_FULL) |=> (stk_cnt_q == $past(stk_cnt_q) + SCW'(1)));

  // R12
  push_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push && stk_cnt_q == STK_FULL) |=> ($stable(stk_cnt_q) && stk_q[0] == $past(ret_addr)));
endmodule

// File: tb/dsp24_core_tb_top.sv
module dsp24_core_tb_top;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned PM_DEPTH   = 256;
  localparam int unsigned PM_AW      = 8;
  localparam int unsigned MAX_CYC    = 1000;

  localparam logic [4:0] F_ADD = 5'b10011;
  localparam logic [4:0] F_MUL = 5'b00100;
  localparam logic [23:0] HALT = 24'hFFFFFF;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              pm_we_i = 1'b0;
  logic [PM_AW-1:0]  pm_addr_i = '0;
  logic [23:0]       pm_wdata_i = '0;
  logic [3:0]        rd_sel_i = '0;
  logic [15:0]       rd_data_o;
  logic              az_o, halted_o;
  logic [15:0]       pc_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [23:0] prog [PM_DEPTH];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dsp24_core #(.PM_DEPTH(PM_DEPTH), .STACK_DEPTH(4)) dut_i (
    .clk_i, .rst_ni, .pm_we_i, .pm_addr_i, .pm_wdata_i,
    .rd_sel_i, .rd_data_o, .az_o, .halted_o, .pc_o
  );

  function automatic logic [23:0] ld_d(input logic [3:0] c, input logic [15:0] v);
    return {4'b0100, v, c};
  endfunction
  function automatic logic [23:0] ld_g1(input logic [3:0] c, input logic [15:0] v);
    return {4'b0101, v, c};
  endfunction
  function automatic logic [23:0] ld_g2(input logic [3:0] c, input logic [15:0] v);
    return {4'b0011, v, c};
  endfunction
  function automatic logic [23:0] comp(input logic [4:0] fn, input logic [1:0] y,
                                       input logic [2:0] x, input logic [3:0] cc);
    return {3'b001, 2'b00, 1'b0, fn, y, x, 4'b0000, cc};
  endfunction
  function automatic logic [23:0] jshort(input logic dly, input logic [12:0] t, input logic [3:0] cc);
    return {4'b0001, 1'b1, 1'b0, dly, t, cc};
  endfunction
  function automatic logic [23:0] jlong(input logic [15:0] t, input logic call, input logic dly);
    return {6'b000111, t[13:0], dly, call, t[15:14]};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] sel, output logic [15:0] v);
    rd_sel_i = sel;
    #1;
    v = rd_data_o;
  endtask

  task automatic chk_reg(input string req, input logic [3:0] sel, input logic [15:0] exp);
    logic [15:0] v;
    rd(sel, v);
    chk(req, $sformatf("sel %0d", sel), {16'h0, v}, {16'h0, exp});
  endtask

  task automatic clear_prog();
    for (int a = 0; a < PM_DEPTH; a++) prog[a] = 24'h000000;
  endtask

  // Loads prog under reset, releases, counts executed words until halt.
  task automatic run_prog(input string req, input int exp_cyc);
    int cyc;
    rst_ni = 1'b0;
    for (int a = 0; a < PM_DEPTH; a++) begin
      pm_addr_i  = PM_AW'(a);
      pm_wdata_i = prog[a];
      pm_we_i    = 1'b1;
      @(negedge clk_i);
    end
    pm_we_i = 1'b0;
    rst_ni  = 1'b1;
    cyc = 0;
    while (!halted_o && cyc < MAX_CYC) begin
      @(negedge clk_i);
      cyc++;
    end
    chk(req, "cycles to halt", cyc, exp_cyc);
  endtask

  task automatic t_loads();
    clear_prog();
    prog[0]  = ld_d(4'd0, 16'h1234);
    prog[1]  = ld_d(4'd1, 16'h5678);
    prog[2]  = ld_d(4'd4, 16'hAAAA);
    prog[3]  = ld_d(4'd2, 16'h4000);
    prog[4]  = ld_d(4'd6, 16'h2000);
    prog[5]  = ld_g1(4'd0, 16'h0100);
    prog[6]  = ld_g1(4'd1, 16'h0200);
    prog[7]  = ld_g2(4'd0, 16'h0300);
    prog[8]  = ld_g1(4'd14, 16'h0064);
    prog[9]  = ld_d(4'd3, 16'hFFFF);   // unused code: no effect
    prog[10] = HALT;
    run_prog("R2", 11);
    chk_reg("R2", 4'd0, 16'h1234);
    chk_reg("R2", 4'd1, 16'h5678);
    chk_reg("R2", 4'd3, 16'hAAAA);
    chk_reg("R2", 4'd2, 16'h4000);
    chk_reg("R2", 4'd4, 16'h2000);
    chk_reg("R2", 4'd5, 16'h0000);
    chk_reg("R3", 4'd8, 16'h0100);
    chk_reg("R3", 4'd9, 16'h0200);
    chk_reg("R3", 4'd10, 16'h0300);
    chk_reg("R3", 4'd11, 16'h0064);
    chk("R14", "halt pc", {16'h0, pc_o}, 32'd10);
    repeat (3) @(negedge clk_i);
    chk("R14", "pc held", {16'h0, pc_o}, 32'd10);
    chk_reg("R14", 4'd0, 16'h1234);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R1", "pc", {16'h0, pc_o}, 32'd0);
    chk("R1", "halted", {31'h0, halted_o}, 32'd0);
    chk("R1", "az", {31'h0, az_o}, 32'd0);
    chk_reg("R1", 4'd0, 16'h0000);
    chk_reg("R1", 4'd11, 16'h0000);
    chk_reg("R1", 4'd13, 16'h0000);
    clear_prog();
    prog[1] = HALT;
    run_prog("R1", 2);
    chk("R13", "nop then halt pc", {16'h0, pc_o}, 32'd1);
  endtask

  task automatic t_arith();
    clear_prog();
    prog[0] = ld_d(4'd1, 16'h0100);
    prog[1] = ld_d(4'd4, 16'hAAAA);
    prog[2] = comp(F_ADD, 2'd0, 3'd1, 4'hF);   // AR = AX1 + AY0 = ABAA
    prog[3] = comp(F_ADD, 2'd0, 3'd2, 4'hF);   // AR = AR + AY0 = 5654
    prog[4] = ld_d(4'd2, 16'hFFFE);
    prog[5] = ld_d(4'd6, 16'h0003);
    prog[6] = comp(F_MUL, 2'd0, 3'd0, 4'hF);   // MR = -2 * 3
    prog[7] = comp(5'b00000, 2'd0, 3'd0, 4'hF); // unsupported fn: no-op
    prog[8] = HALT;
    run_prog("R4", 9);
    chk_reg("R4", 4'd5, 16'h5654);
    chk("R4", "az", {31'h0, az_o}, 32'd0);
    chk_reg("R5", 4'd6, 16'hFFFA);
    chk_reg("R5", 4'd7, 16'hFFFF);
    chk_reg("R13", 4'd5, 16'h5654);

    clear_prog();
    prog[0] = ld_d(4'd0, 16'h0001);
    prog[1] = ld_d(4'd4, 16'hFFFF);
    prog[2] = comp(F_ADD, 2'd0, 3'd0, 4'hF);   // AR = 0
    prog[3] = ld_d(4'd2, 16'h4000);
    prog[4] = ld_d(4'd6, 16'h2000);
    prog[5] = comp(F_MUL, 2'd0, 3'd0, 4'hF);
    prog[6] = HALT;
    run_prog("R4", 7);
    chk_reg("R4", 4'd5, 16'h0000);
    chk("R4", "az after zero sum", {31'h0, az_o}, 32'd1);
    chk_reg("R5", 4'd7, 16'h0800);
    chk_reg("R5", 4'd6, 16'h0000);
  endtask

  task automatic t_cond();
    clear_prog();
    prog[0] = ld_d(4'd0, 16'h0001);
    prog[1] = ld_d(4'd4, 16'hFFFF);
    prog[2] = comp(F_ADD, 2'd0, 3'd0, 4'hF);   // az = 1
    prog[3] = ld_d(4'd1, 16'h0003);
    prog[4] = ld_d(4'd0, 16'h0005);
    prog[5] = ld_d(4'd4, 16'h0002);
    prog[6] = comp(F_ADD, 2'd0, 3'd0, 4'h0);   // EQ true: AR = 7, az = 0
    prog[7] = comp(F_ADD, 2'd0, 3'd1, 4'h0);   // EQ false: skipped
    prog[8] = comp(F_ADD, 2'd0, 3'd1, 4'h2);   // other code: never
    prog[9] = comp(F_ADD, 2'd0, 3'd2, 4'h1);   // NE true: AR = 9
    prog[10] = HALT;
    run_prog("R6", 11);
    chk_reg("R6", 4'd5, 16'h0009);
    chk("R6", "az", {31'h0, az_o}, 32'd0);
  endtask

  task automatic t_short(input logic dly);
    clear_prog();
    prog[0] = ld_d(4'd0, 16'h0001);
    prog[1] = jshort(dly, 13'd4, 4'hF);
    prog[2] = ld_d(4'd0, 16'h2222);
    prog[3] = ld_d(4'd1, 16'h3333);
    prog[4] = ld_d(4'd4, 16'h4444);
    prog[5] = HALT;
    if (!dly) begin
      run_prog("R7", 4);
      chk_reg("R7", 4'd0, 16'h0001);
      chk_reg("R7", 4'd1, 16'h0000);
      chk_reg("R7", 4'd3, 16'h4444);
    end else begin
      run_prog("R8", 6);
      chk_reg("R8", 4'd0, 16'h2222);
      chk_reg("R8", 4'd1, 16'h3333);
      chk_reg("R8", 4'd3, 16'h4444);
    end
  endtask

  task automatic t_eq_jump();
    clear_prog();
    prog[0] = jshort(1'b0, 13'd4, 4'h0);       // az = 0: not taken
    prog[1] = ld_d(4'd0, 16'h0001);
    prog[2] = ld_d(4'd4, 16'hFFFF);
    prog[3] = comp(F_ADD, 2'd0, 3'd0, 4'hF);   // az = 1
    prog[4] = jshort(1'b0, 13'd7, 4'h0);       // taken
    prog[5] = ld_d(4'd1, 16'h5555);
    prog[6] = HALT;
    prog[7] = ld_d(4'd2, 16'h7777);
    prog[8] = HALT;
    run_prog("R7", 7);
    chk_reg("R7", 4'd0, 16'h0001);
    chk_reg("R7", 4'd1, 16'h0000);
    chk_reg("R7", 4'd2, 16'h7777);
    chk("R7", "pc", {16'h0, pc_o}, 32'd8);
  endtask

  task automatic t_long();
    clear_prog();
    prog[0]    = jlong(16'h4010, 1'b0, 1'b0);
    prog[1]    = ld_d(4'd0, 16'h1111);
    prog[2]    = HALT;
    prog[8'h10] = ld_d(4'd4, 16'h0AB0);
    prog[8'h11] = HALT;
    run_prog("R9", 3);
    chk("R9", "pc split target", {16'h0, pc_o}, 32'h4011);
    chk_reg("R9", 4'd0, 16'h0000);
    chk_reg("R9", 4'd3, 16'h0AB0);
  endtask

  task automatic t_call();
    clear_prog();
    prog[0]     = ld_d(4'd0, 16'h0001);
    prog[1]     = jlong(16'h0020, 1'b1, 1'b1);
    prog[2]     = ld_d(4'd1, 16'h0002);
    prog[3]     = ld_d(4'd2, 16'h0003);
    prog[4]     = ld_d(4'd6, 16'h0004);
    prog[8'h20] = HALT;
    run_prog("R10", 5);
    chk_reg("R10", 4'd12, 16'h0004);
    chk_reg("R10", 4'd13, 16'h0001);
    chk_reg("R8", 4'd2, 16'h0003);
    chk_reg("R8", 4'd4, 16'h0000);

    clear_prog();
    prog[8'h00] = jlong(16'h0010, 1'b1, 1'b0);
    prog[8'h10] = jlong(16'h0020, 1'b1, 1'b0);
    prog[8'h20] = jlong(16'h0030, 1'b1, 1'b0);
    prog[8'h30] = jlong(16'h0040, 1'b1, 1'b0);
    prog[8'h40] = jlong(16'h0050, 1'b1, 1'b0);
    prog[8'h50] = HALT;
    run_prog("R12", 6);
    chk_reg("R12", 4'd13, 16'h0004);
    chk_reg("R12", 4'd12, 16'h0041);
  endtask

  task automatic t_misc();
    clear_prog();
    prog[0]     = 24'h800000;                   // undecoded
    prog[1]     = 24'h6ABCD0;                   // undecoded
    prog[2]     = jlong(16'h0010, 1'b0, 1'b1);
    prog[3]     = jshort(1'b0, 13'd48, 4'hF);   // in slot: ignored
    prog[4]     = ld_d(4'd0, 16'h0044);
    prog[8'h10] = HALT;
    prog[8'h30] = ld_d(4'd1, 16'hBAD0);
    run_prog("R11", 6);
    chk("R11", "pc", {16'h0, pc_o}, 32'h0010);
    chk_reg("R11", 4'd0, 16'h0044);
    chk_reg("R11", 4'd1, 16'h0000);
    chk_reg("R13", 4'd5, 16'h0000);
    chk_reg("R13", 4'd3, 16'h0000);
  endtask

  initial begin
    t_loads();
    t_reset();
    t_arith();
    t_cond();
    t_short(1'b0);
    t_short(1'b1);
    t_eq_jump();
    t_long();
    t_call();
    t_misc();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule